// File: doc/BRIEF.md
# Power line frequency classifier

This block decides whether the mains supply feeding an instrument is a 60 Hz or a 50 Hz network. A digital square wave derived from the mains arrives asynchronously on `line_sense`. The block synchronizes it and times the interval between consecutive rising edges in reference clock cycles. It accepts an interval only if it lies inside the window that corresponds to 55 Hz to 66 Hz. Any interval outside that window, and any missing signal, selects the 50 Hz standard.

The decision drives an integrating measurement converter. It is reported as a mode flag and as the length of one nominal line cycle in clock cycles. The integration period is CLK_HZ/60 for the 60 Hz standard and CLK_HZ/50 for the 50 Hz standard. A one-cycle strobe marks every update. Timing runs only while `meas_en` is high. The first rising edge after enable starts a fresh interval and produces no decision.

Top module: `line_freq_classifier`

## Requirements
- R1: While reset is low, and after reset, `std_is_60` is 0 (0 encodes the 50 Hz standard, 1 the 60 Hz standard), `int_period` equals CLK_HZ/50 and `result_valid` is 0, until the first decision.
- R2: An interval between consecutive synchronized rising edges of P clock cycles, with CLK_HZ/66 <= P <= CLK_HZ/55 (integer division, both bounds inclusive), yields `std_is_60` = 1 and `int_period` = CLK_HZ/60.
- R3: An interval P below CLK_HZ/66 or above CLK_HZ/55 yields `std_is_60` = 0 and `int_period` = CLK_HZ/50.
- R4: Each completed edge-to-edge interval produces exactly one `result_valid` pulse carrying the decision for that interval. The pulse appears within 8 clock cycles of the closing edge at the pin.
- R5: The first rising edge seen after `meas_en` goes high, and the first edge after a timeout, only start timing and produce no `result_valid` pulse.
- R6: While `meas_en` is low, no `result_valid` pulse is produced and `std_is_60` and `int_period` hold their values.
- R7: If no rising edge follows a timed edge within TMO = CLK_HZ/55 + (CLK_HZ/55)/4 cycles, one `result_valid` pulse reports the 50 Hz standard. No further pulse follows until two new edges have been seen.
- R8: `result_valid` is never high for two consecutive cycles, and `std_is_60` and `int_period` change only in the cycle in which `result_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock of CLK_HZ hertz |
| rst_n | input | 1 | Synchronous reset, active low |
| line_sense | input | 1 | Asynchronous mains-derived square wave |
| meas_en | input | 1 | Enables interval timing |
| std_is_60 | output | 1 | 1: 60 Hz standard, 0: 50 Hz standard |
| int_period | output | CNT_W | Clock cycles in one nominal line cycle of the selected standard |
| result_valid | output | 1 | One-cycle strobe marking a new decision |

## Verification
The table run sits on both window bounds and one cycle outside each. A design with an off-by-one counter start or a strict comparison would misclassify 1000, 999, 1200 or 1201 cycles at the bench's 66 kHz reference. Directed tests remove the edges after a 60 Hz result: a design with no timeout would keep reporting 60 Hz, and one that did not disarm would strobe repeatedly or decide on the half interval that follows. Toggling `meas_en` checks that disabled edges are ignored and that the partial interval after re-enable is discarded. A design that kept stale timing would report a bogus interval spanning the disabled stretch.

// File: rtl/lfc_pkg.sv
// Package: shared constants and derivations for the line frequency classifier.
// Assumes the clock frequency is an integer number of hertz, well above 66 Hz.
package lfc_pkg;

    typedef enum logic {
        STD_50HZ = 1'b0,
        STD_60HZ = 1'b1
    } line_std_e;

    // Shortest accepted line period (66 Hz), in clock cycles.
    function automatic int unsigned per_lo(input int unsigned clk_hz);
        return clk_hz / 66;
    endfunction

    // Longest accepted line period (55 Hz), in clock cycles.
    function automatic int unsigned per_hi(input int unsigned clk_hz);
        return clk_hz / 55;
    endfunction

    // Silence limit after an edge: the longest accepted period plus a quarter.
    function automatic int unsigned tmo_cycles(input int unsigned clk_hz);
        return per_hi(clk_hz) + per_hi(clk_hz) / 4;
    endfunction

    // One nominal 60 Hz line cycle in clock cycles.
    function automatic int unsigned per_60(input int unsigned clk_hz);
        return clk_hz / 60;
    endfunction

    // One nominal 50 Hz line cycle in clock cycles.
    function automatic int unsigned per_50(input int unsigned clk_hz);
        return clk_hz / 50;
    endfunction

endpackage

// File: rtl/lfc_edge_sync.sv
// Module: brings the asynchronous line sense input into the clock domain
// through a two-flop synchronizer. It flags each rising edge with a
// one-cycle pulse.
// Assumes the input stays at each level for more than two clock cycles.
module lfc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the input through the synchronizer stages and keep one stage of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge: synchronized level high while the previous level was low.
    always_comb begin
        rise_pulse = sync_q[STAGES-1] & ~last_q;
    end

endmodule

// File: rtl/lfc_period_timer.sv
// Module: times the interval between consecutive rising edges in clock cycles.
// The first edge after enable, or after a timeout, only arms the timer.
// After TMO cycles without an edge it raises one timeout pulse and disarms.
// Assumes edge pulses are at least two cycles apart.
module lfc_period_timer #(
    parameter int unsigned TMO   = 1500,
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             edge_pulse,
    output logic             meas_stb,
    output logic [CNT_W-1:0] meas_cycles,
    output logic             tmo_stb
);

    localparam logic [CNT_W-1:0] TMO_C = CNT_W'(TMO);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    // Count cycles since the last edge, report full intervals and silence.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            armed_q     <= 1'b0;
            cnt_q       <= '0;
            meas_stb    <= 1'b0;
            meas_cycles <= '0;
            tmo_stb     <= 1'b0;
        end else begin
            meas_stb <= 1'b0;
            tmo_stb  <= 1'b0;
            if (edge_pulse) begin
                if (armed_q) begin
                    meas_stb    <= 1'b1;
                    meas_cycles <= cnt_q;
                end
                armed_q <= 1'b1;
                cnt_q   <= ONE_C;
            end else if (armed_q) begin
                if (cnt_q == TMO_C) begin
                    tmo_stb <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + ONE_C;
                end
            end
        end
    end

endmodule

// File: rtl/lfc_decide.sv
// Module: turns a measured interval, or a timeout, into the frequency
// standard and the matching integration period. Registers both with a strobe.
// Assumes meas_stb and tmo_stb are never high together.
module lfc_decide #(
    parameter int unsigned LO    = 1000,
    parameter int unsigned HI    = 1200,
    parameter int unsigned P60   = 1100,
    parameter int unsigned P50   = 1320,
    parameter int unsigned CNT_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     meas_stb,
    input  logic [CNT_W-1:0]         meas_cycles,
    input  logic                     tmo_stb,
    output lfc_pkg::line_std_e       std_q,
    output logic [CNT_W-1:0]         period_q,
    output logic                     valid_q
);

    localparam logic [CNT_W-1:0] LO_C  = CNT_W'(LO);
    localparam logic [CNT_W-1:0] HI_C  = CNT_W'(HI);
    localparam logic [CNT_W-1:0] P60_C = CNT_W'(P60);
    localparam logic [CNT_W-1:0] P50_C = CNT_W'(P50);

    logic in_window;

    // Window test with both bounds inclusive.
    always_comb begin
        in_window = (meas_cycles >= LO_C) && (meas_cycles <= HI_C);
    end

    // Latch a new decision on each measurement or timeout; default to 50 Hz.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_q    <= lfc_pkg::STD_50HZ;
            period_q <= P50_C;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= meas_stb | tmo_stb;
            if (meas_stb && in_window) begin
                std_q    <= lfc_pkg::STD_60HZ;
                period_q <= P60_C;
            end else if (meas_stb || tmo_stb) begin
                std_q    <= lfc_pkg::STD_50HZ;
                period_q <= P50_C;
            end
        end
    end

endmodule

// File: rtl/line_freq_classifier.sv
// Module: top of the power line frequency classifier. It chains the
// synchronizer, the period timer and the decision stage.
// Assumes CLK_HZ is well above 66 Hz, so the accepted window spans many cycles.
module line_freq_classifier
    import lfc_pkg::*;
#(
    parameter  int unsigned CLK_HZ = 100_000_000,
    localparam int unsigned TMO    = tmo_cycles(CLK_HZ),
    localparam int unsigned CNT_W  = $clog2(TMO + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_sense,
    input  logic             meas_en,
    output logic             std_is_60,
    output logic [CNT_W-1:0] int_period,
    output logic             result_valid
);

    logic             rise;
    logic             meas_stb;
    logic [CNT_W-1:0] meas_cycles;
    logic             tmo_stb;
    line_std_e        std_sel;

    lfc_edge_sync #(
        .STAGES (2)
    ) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (line_sense),
        .rise_pulse (rise)
    );

    lfc_period_timer #(
        .TMO   (TMO),
        .CNT_W (CNT_W)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (meas_en),
        .edge_pulse  (rise),
        .meas_stb    (meas_stb),
        .meas_cycles (meas_cycles),
        .tmo_stb     (tmo_stb)
    );

    lfc_decide #(
        .LO    (per_lo(CLK_HZ)),
        .HI    (per_hi(CLK_HZ)),
        .P60   (per_60(CLK_HZ)),
        .P50   (per_50(CLK_HZ)),
        .CNT_W (CNT_W)
    ) decide_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .meas_stb    (meas_stb),
        .meas_cycles (meas_cycles),
        .tmo_stb     (tmo_stb),
        .std_q       (std_sel),
        .period_q    (int_period),
        .valid_q     (result_valid)
    );

    // Present the standard as a plain flag.
    always_comb begin
        std_is_60 = (std_sel == STD_60HZ);
    end

endmodule

// File: rtl/lfc_checker.sv
// Module: assertion checker for line_freq_classifier, attached by bind.
// Assumes reset is held low from time zero.
module lfc_checker #(
    parameter int unsigned CLK_HZ = 100_000_000,
    parameter int unsigned CNT_W  = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meas_en,
    input logic             std_is_60,
    input logic [CNT_W-1:0] int_period,
    input logic             result_valid
);

    localparam logic [CNT_W-1:0] P60_C = CNT_W'(lfc_pkg::per_60(CLK_HZ));
    localparam logic [CNT_W-1:0] P50_C = CNT_W'(lfc_pkg::per_50(CLK_HZ));

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!result_valid && !std_is_60 && int_period == P50_C)); // R1

    AST_PERIOD_MATCHES_STD: assert property (@(posedge clk) disable iff (!rst_n)
        int_period == (std_is_60 ? P60_C : P50_C)); // R2

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_en && $past(!meas_en) && $past(!meas_en, 2)) |-> !result_valid); // R6

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R8

    AST_HOLD_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(std_is_60) && $stable(int_period))); // R8

endmodule

bind line_freq_classifier lfc_checker #(
    .CLK_HZ (CLK_HZ),
    .CNT_W  (CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .meas_en      (meas_en),
    .std_is_60    (std_is_60),
    .int_period   (int_period),
    .result_valid (result_valid)
);

// File: tb/line_freq_classifier_tb_top.sv
// Bench: table-driven interval classification, then directed tests for
// reset, discard of the first edge, timeout and enable gating.
module line_freq_classifier_tb_top;

    localparam int unsigned CLK_HZ = 66_000;
    localparam int LO    = CLK_HZ / 66;
    localparam int HI    = CLK_HZ / 55;
    localparam int TMO   = HI + HI / 4;
    localparam int P60   = CLK_HZ / 60;
    localparam int P50   = CLK_HZ / 50;
    localparam int CNT_W = $clog2(TMO + 1);
    localparam int NVEC  = 8;
    localparam int VPER [NVEC] = '{1100, LO, LO - 1, HI, HI + 1, 1320, 900, 1050};
    localparam bit VEXP [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_sense = 1'b0;
    logic             meas_en = 1'b0;
    logic             std_is_60;
    logic [CNT_W-1:0] int_period;
    logic             result_valid;

    int errors = 0;
    int checks = 0;
    int vcnt = 0;
    int wide = 0;
    int since_rise = 0;
    int base = 0;
    bit prev_v = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    line_freq_classifier #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_sense   (line_sense),
        .meas_en      (meas_en),
        .std_is_60    (std_is_60),
        .int_period   (int_period),
        .result_valid (result_valid)
    );

    // Count strobes and catch strobes wider than one cycle, sampled off the edge.
    always @(negedge clk) begin
        if (rst_n && result_valid) vcnt++;
        if (rst_n && result_valid && prev_v) wide++;
        prev_v = rst_n && result_valid;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        since_rise++;
    endtask

    // Drive the next rising edge p cycles after the previous one.
    task automatic rise_after(input int p);
        while (since_rise < p / 2) tick();
        line_sense = 1'b0;
        while (since_rise < p) tick();
        line_sense = 1'b1;
        since_rise = 0;
    endtask

    task automatic settle();
        while (since_rise < 8) tick();
    endtask

    initial begin
        repeat (2000_00 - 50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 flag in reset", int'(std_is_60), 0);
        check("R1 period in reset", int'(int_period), P50);
        check("R1 strobe in reset", int'(result_valid), 0);
        rst_n = 1'b1;
        meas_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 period after reset", int'(int_period), P50);

        // R5: first edge after enable only arms
        line_sense = 1'b1;
        since_rise = 0;
        base = vcnt;
        settle();
        check("R5 first edge no strobe", vcnt, base);

        // R2 R3 R4: table walk over window bounds and outside values
        for (int i = 0; i < NVEC; i++) begin
            base = vcnt;
            rise_after(VPER[i]);
            settle();
            check($sformatf("R4 one strobe p=%0d", VPER[i]), vcnt, base + 1);
            check($sformatf("%s flag p=%0d", VEXP[i] ? "R2" : "R3", VPER[i]),
                  int'(std_is_60), int'(VEXP[i]));
            check($sformatf("%s period p=%0d", VEXP[i] ? "R2" : "R3", VPER[i]),
                  int'(int_period), VEXP[i] ? P60 : P50);
        end

        // R7: silence after a 60 Hz decision falls back to 50 Hz once
        base = vcnt;
        while (since_rise < TMO + 20) tick();
        check("R7 timeout strobe", vcnt, base + 1);
        check("R7 timeout flag", int'(std_is_60), 0);
        check("R7 timeout period", int'(int_period), P50);
        while (since_rise < 2 * TMO + 40) tick();
        check("R7 no repeat strobe", vcnt, base + 1);
        base = vcnt;
        line_sense = 1'b0;
        repeat (20) tick();
        line_sense = 1'b1;
        since_rise = 0;
        settle();
        check("R7 R5 re-arm edge no strobe", vcnt, base);
        rise_after(1100);
        settle();
        check("R7 recovery strobe", vcnt, base + 1);
        check("R7 recovery flag", int'(std_is_60), 1);

        // R6: edges ignored while disabled
        meas_en = 1'b0;
        base = vcnt;
        rise_after(LO);
        settle();
        rise_after(1100);
        settle();
        check("R6 no strobe disabled", vcnt, base);
        check("R6 flag held", int'(std_is_60), 1);
        check("R6 period held", int'(int_period), P60);

        // R5: partial interval after re-enable is discarded
        meas_en = 1'b1;
        rise_after(1320);
        settle();
        check("R5 re-enable first edge no strobe", vcnt, base);
        rise_after(1320);
        settle();
        check("R5 after re-enable strobe", vcnt, base + 1);
        check("R3 after re-enable flag", int'(std_is_60), 0);

        // R1: reset mid-run after a 60 Hz decision
        rise_after(1100);
        settle();
        check("R2 before reset flag", int'(std_is_60), 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 flag after reset", int'(std_is_60), 0);
        check("R1 period after reset", int'(int_period), P50);
        rst_n = 1'b1;

        // R8: strobe width over the whole run
        check("R8 wide strobes", wide, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule